// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block keeps a word of pending interrupt causes and turns it into two forms of interrupt signalling. Software sets cause bits by writing a value to a raise register. The value is ORed into the pending word. Software clears cause bits by writing a mask to an acknowledge register. A read-only view of the word lets an interrupt handler see which causes are pending. Neighbouring hardware units also report completion through single-cycle event inputs. Each event input ORs a fixed code into the word when its enable input is high.

Two outputs carry the interrupt. A level line stays high while any cause bit is pending and the level-enable input is high. A message pulse lasts one cycle and fires when message mode is selected and a raise or an event turns on at least one bit that was clear before. The pending word stays set in message mode too, so a handler must always acknowledge to clear the state.

Top module: `irq_status_hub`

## Requirements
- R1: While `rst` is high at a clock edge, the pending word becomes 0 and `irq_level`, `irq_msg_pulse` and `reg_rdata` become 0.
- R2: A write (`reg_wr`=1) to byte offset 0x60 ORs `reg_wdata` into the pending word at that clock edge.
- R3: A write to byte offset 0x64 clears every pending bit whose `reg_wdata` bit is 1. No other path lowers a pending bit.
- R4: A read (`reg_rd`=1) at offset 0x24 returns the pending word from before that edge on `reg_rdata`, one cycle later. A read at any other offset returns 0. Writes to 0x24 or to any offset other than 0x60 and 0x64 leave the pending word unchanged.
- R5: Event input 0 ORs code 0x001 and event input 1 ORs code 0x100 into the pending word when the matching `evt_en` bit is high. An event whose enable is low has no effect.
- R6: If a bit is set by a raise or an event in the same cycle that an acknowledge clears it, the bit ends up set.
- R7: `irq_level` equals the registered value of `level_en` AND (pending word != 0). It updates on the same edge as the pending word.
- R8: `irq_msg_pulse` is high for exactly the one cycle after an edge where `msg_mode` was 1 and a raise or event set at least one previously clear bit. A raise of bits that are already pending produces no pulse.
- R9: A raise or event and an acknowledge in one cycle combine as (old AND NOT ack) OR set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, one cycle after `reg_rd` |
| evt_pulse | input | NUM_EVT | Single-cycle hardware completion events |
| evt_en | input | NUM_EVT | Per-event interrupt enables |
| level_en | input | 1 | Enables the level interrupt line |
| msg_mode | input | 1 | Selects message-style pulse signalling |
| irq_level | output | 1 | Level interrupt line |
| irq_msg_pulse | output | 1 | One-cycle message request |

## Verification
The bench builds the block with a 12-bit pending word, an 8-bit offset and two event sources. At this width, a sweep of 32 by 32 spread raise and acknowledge values touches every bit position, and each result is compared with a model computed in the bench. Both event codes fit in the word, so the bench can drive every combination of event pulse and enable against a simultaneous all-ones acknowledge. This exercises set-over-clear priority and event-plus-raise merging. Message mode alternates through the sweep, so pulses are checked both when they must fire and when they must not.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Fixed cause code for each hardware event source index.
  function automatic logic [63:0] evt_code_of(input int idx);
    logic [63:0] code;
    if (idx == 0)      code = 64'h1;
    else if (idx == 1) code = 64'h100;
    else               code = 64'h1 << (idx + 8);
    return code;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
  parameter int ADDR_W    = 8,
  parameter int OFF_STAT  = 'h24,
  parameter int OFF_RAISE = 'h60,
  parameter int OFF_ACK   = 'h64
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              raise_stb,
  output logic              ack_stb,
  output logic              stat_rd
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFF_RAISE);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);

  always_comb begin
    raise_stb = wr && (addr == A_RAISE);
    ack_stb   = wr && (addr == A_ACK);
    stat_rd   = rd && (addr == A_STAT);
  end
endmodule

// File: rtl/irq_event_encode.sv
module irq_event_encode
  import irq_hub_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 2
) (
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_en,
  output logic [DATA_W-1:0]  evt_set
);
  logic [DATA_W-1:0] per_src [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_src
    localparam logic [DATA_W-1:0] CODE = DATA_W'(evt_code_of(i));
    assign per_src[i] = (evt_pulse[i] && evt_en[i]) ? CODE : '0;
  end

  always_comb begin
    evt_set = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_set = evt_set | per_src[i];
  end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raise_stb,
  input  logic              ack_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evt_set,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] status_nxt,
  output logic [DATA_W-1:0] new_bits
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    set_vec    = (raise_stb ? wdata : '0) | evt_set;
    clr_vec    = ack_stb ? wdata : '0;
    // set dominates clear for the same bit
    status_nxt = (status_q & ~clr_vec) | set_vec;
    new_bits   = set_vec & ~status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_nxt;
  end
endmodule

// File: rtl/irq_signal_out.sv
module irq_signal_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              level_en,
  input  logic              msg_mode,
  input  logic [DATA_W-1:0] status_nxt,
  input  logic [DATA_W-1:0] new_bits,
  output logic              irq_level,
  output logic              irq_msg_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level     <= 1'b0;
      irq_msg_pulse <= 1'b0;
    end else begin
      irq_level     <= level_en && (|status_nxt);
      irq_msg_pulse <= msg_mode && (|new_bits);
    end
  end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_EVT   = 2,
  parameter int OFF_STAT  = 'h24,
  parameter int OFF_RAISE = 'h60,
  parameter int OFF_ACK   = 'h64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic               level_en,
  input  logic               msg_mode,
  output logic               irq_level,
  output logic               irq_msg_pulse
);
  logic              raise_stb;
  logic              ack_stb;
  logic              stat_rd;
  logic [DATA_W-1:0] evt_set;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] status_nxt;
  logic [DATA_W-1:0] new_bits;

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .OFF_STAT(OFF_STAT),
    .OFF_RAISE(OFF_RAISE), .OFF_ACK(OFF_ACK)
  ) u_dec (
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .raise_stb(raise_stb), .ack_stb(ack_stb), .stat_rd(stat_rd)
  );

  irq_event_encode #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_evt (
    .evt_pulse(evt_pulse), .evt_en(evt_en), .evt_set(evt_set)
  );

  irq_status_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst),
    .raise_stb(raise_stb), .ack_stb(ack_stb), .wdata(reg_wdata),
    .evt_set(evt_set),
    .status_q(status_q), .status_nxt(status_nxt), .new_bits(new_bits)
  );

  irq_signal_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst),
    .level_en(level_en), .msg_mode(msg_mode),
    .status_nxt(status_nxt), .new_bits(new_bits),
    .irq_level(irq_level), .irq_msg_pulse(irq_msg_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (stat_rd) reg_rdata <= status_q;
    else              reg_rdata <= '0;
  end
endmodule

// File: rtl/irq_status_hub_chk.sv
module irq_status_hub_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int OFF_RAISE = 'h60,
  parameter int OFF_ACK   = 'h64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              level_en,
  input logic              msg_mode,
  input logic [DATA_W-1:0] status,
  input logic              irq_level,
  input logic              irq_msg_pulse
);
  logic raise_w;
  logic ack_w;
  assign raise_w = reg_wr && (reg_addr == ADDR_W'(OFF_RAISE));
  assign ack_w   = reg_wr && (reg_addr == ADDR_W'(OFF_ACK));

  assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
    raise_w |=> ((status & $past(reg_wdata)) == $past(reg_wdata)));

  assert_only_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    !ack_w |=> ((status & $past(status)) == $past(status)));

  assert_level_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_level == ($past(level_en) && (status != '0))));

  assert_pulse_needs_mode_R8: assert property (@(posedge clk) disable iff (rst)
    !msg_mode |=> !irq_msg_pulse);

  assert_pulse_new_bits_R8: assert property (@(posedge clk) disable iff (rst)
    irq_msg_pulse |-> ((status & ~$past(status)) != '0));
endmodule

bind irq_status_hub irq_status_hub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_RAISE(OFF_RAISE), .OFF_ACK(OFF_ACK)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .level_en(level_en), .msg_mode(msg_mode),
  .status(status_q), .irq_level(irq_level), .irq_msg_pulse(irq_msg_pulse)
);

// File: tb/tb_irq_status_hub.sv
`timescale 1ns/1ps
module tb_irq_status_hub;
  localparam int AW = 8;
  localparam int DW = 12;
  localparam int NE = 2;
  localparam logic [DW-1:0] ALL = '1;
  localparam logic [AW-1:0] A_STAT = 8'h24, A_RAISE = 8'h60, A_ACK = 8'h64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NE-1:0] evt_pulse = '0, evt_en = '0;
  logic          level_en = 1'b1, msg_mode = 1'b0;
  logic          irq_level, irq_msg_pulse;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_status_hub #(.ADDR_W(AW), .DATA_W(DW), .NUM_EVT(NE)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .evt_en(evt_en), .level_en(level_en),
    .msg_mode(msg_mode), .irq_level(irq_level), .irq_msg_pulse(irq_msg_pulse)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one write for one edge; returns at the negedge after it
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  logic [DW-1:0] got;
  logic [DW-1:0] exp_s;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(32'(irq_level), 0, "R1 level");
    check(32'(irq_msg_pulse), 0, "R1 pulse");
    check(32'(reg_rdata), 0, "R1 rdata");
    rst = 1'b0;
    rd(A_STAT, got);
    check(32'(got), 0, "R1 status");

    // sweep of raise/ack patterns (R2, R3, R7, R8)
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [DW-1:0] rv, av;
        rv = DW'(a * 'h85);
        av = DW'(b * 'h93);
        msg_mode = a[0] ^ b[0];
        wr(A_ACK, ALL);
        check(32'(irq_level), 0, "R3 cleared level");
        wr(A_RAISE, rv);
        check(32'(irq_msg_pulse), 32'(msg_mode && rv != 0), "R8 pulse on new bits");
        check(32'(irq_level), 32'(rv != 0), "R7 level after raise");
        wr(A_RAISE, rv);
        check(32'(irq_msg_pulse), 0, "R8 no pulse on repeat");
        rd(A_STAT, got);
        check(32'(got), 32'(rv), "R2 raise value");
        wr(A_ACK, av);
        rd(A_STAT, got);
        check(32'(got), 32'(rv & ~av), "R3 ack clears");
        check(32'(irq_level), 32'((rv & ~av) != 0), "R7 level after ack");
      end
    end

    // R4: offsets and ignored writes
    msg_mode = 1'b0;
    wr(A_ACK, ALL);
    wr(A_RAISE, 12'h5A5);
    wr(A_STAT, ALL);
    wr(8'h20, ALL);
    rd(A_STAT, got);
    check(32'(got), 32'h5A5, "R4 ignored writes");
    rd(A_RAISE, got);
    check(32'(got), 0, "R4 read other offset");
    rd(A_ACK, got);
    check(32'(got), 0, "R4 read ack offset");

    // R7: level enable gating
    @(negedge clk); level_en = 1'b0;
    @(negedge clk);
    check(32'(irq_level), 0, "R7 gated off");
    level_en = 1'b1;
    @(negedge clk);
    check(32'(irq_level), 1, "R7 gated on");

    // R5, R6: events against a simultaneous full ack
    for (int m = 0; m < 2; m++) begin
      for (int en = 0; en < 4; en++) begin
        for (int p = 0; p < 4; p++) begin
          msg_mode = m[0];
          wr(A_ACK, ALL);
          exp_s = '0;
          if (p[0] && en[0]) exp_s |= 12'h001;
          if (p[1] && en[1]) exp_s |= 12'h100;
          @(negedge clk);
          evt_en = NE'(en); evt_pulse = NE'(p);
          reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = ALL;
          @(negedge clk);
          evt_pulse = '0; reg_wr = 1'b0;
          check(32'(irq_msg_pulse), 32'(m[0] && exp_s != 0), "R8 event pulse");
          rd(A_STAT, got);
          check(32'(got), 32'(exp_s), "R5 R6 event code set wins");
        end
      end
    end

    // R9: raise plus event, then event with partial ack
    msg_mode = 1'b1;
    evt_en = 2'b11;
    wr(A_ACK, ALL);
    @(negedge clk);
    evt_pulse = 2'b01; reg_wr = 1'b1; reg_addr = A_RAISE; reg_wdata = 12'h0F0;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0;
    rd(A_STAT, got);
    check(32'(got), 32'h0F1, "R9 raise and event merge");
    @(negedge clk);
    evt_pulse = 2'b10; reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = 12'h031;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0;
    check(32'(irq_msg_pulse), 1, "R8 event new bit pulse");
    rd(A_STAT, got);
    check(32'(got), 32'h1C0, "R9 ack with event");
    // R6: event on an already pending bit with ack of that bit
    @(negedge clk);
    evt_pulse = 2'b10; reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = 12'h100;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0;
    check(32'(irq_msg_pulse), 0, "R8 no pulse pending bit");
    rd(A_STAT, got);
    check(32'(got), 32'h1C0, "R6 set wins on pending bit");

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(32'(irq_level), 0, "R1 level after reset");
    rst = 1'b0;
    rd(A_STAT, got);
    check(32'(got), 0, "R1 status after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule